// File: doc/BRIEF.md
# Shared Command Queue Admission

This block is a single in-order command queue fed by two request classes. Processor-class commands have a reserved share of the queue. Accelerator-class commands may hold only a capped number of entries at any one time. Each class has its own valid/ready enqueue port. One dequeue port drains the queue toward the memory side, in the order the commands were accepted. Each dequeued command carries a tag that names its class.

An 8-bit limit register, written by software, sets the accelerator cap. The block counts the accelerator entries currently in the queue. When that count has reached the cap, the accelerator ready stays low until dequeues bring the count back under it. A limit of zero is not legal, so the block treats it as one. This keeps accelerator traffic from being shut out for good. Processor commands are held back only by a full queue.

Top module: `cmdq_share_adm`

## Requirements
- R1: After reset the queue is empty (`deq_valid` low) and `lim_q` reads 2.
- R2: A cycle with `lim_we` high loads `lim_wdata` into the limit, and `lim_q` shows it from the next cycle on. The new value governs admission from that next cycle.
- R3: `acc_ready` is low whenever the number of accelerator entries in the queue is equal to or above the effective limit. It rises again once dequeues bring that number below the limit. This also applies after the limit is lowered under the current count.
- R4: A limit value of 0 admits accelerator commands exactly as a limit of 1 does.
- R5: `cpu_ready` is high whenever the queue holds fewer than its depth (default 64) entries, whatever the accelerator count and limit.
- R6: When both classes are accepted in the same cycle, the processor command takes the earlier queue position. An accelerator command offered alongside an accepted processor command is accepted only if at least two entries are free and its cap allows.
- R7: Commands leave on `deq_data` in exactly the order they were accepted across both classes, with none lost or duplicated. This holds while the limit is rewritten during traffic.
- R8: `deq_is_acc` is 1 for a command that entered through the accelerator port and 0 for one from the processor port. Only the dequeue of an entry with tag 1 lowers the accelerator count.
- R9: Both ready outputs are decided from the queue state held at the start of the cycle. With the queue full, both readies are low, even in a cycle that dequeues. The freed slot is offered from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_we | input | 1 | Limit register write strobe |
| lim_wdata | input | 8 | Value written to the limit register |
| lim_q | output | 8 | Current limit register value |
| cpu_valid | input | 1 | Processor-class command offered |
| cpu_ready | output | 1 | Processor-class command accepted when valid |
| cpu_data | input | DATA_W | Processor-class command word |
| acc_valid | input | 1 | Accelerator-class command offered |
| acc_ready | output | 1 | Accelerator-class command accepted when valid |
| acc_data | input | DATA_W | Accelerator-class command word |
| deq_valid | output | 1 | Queue head holds a command |
| deq_ready | input | 1 | Consumer takes the head command |
| deq_data | output | DATA_W | Head command word |
| deq_is_acc | output | 1 | Head command class tag, 1 for accelerator |

## Verification
The bench goes after the moment the accelerator count meets the cap. A design that compares with the wrong sign would admit one command too many, or would stall a slot early. It also lowers the limit under the live count. A design that tested only for equality would then run past the cap. A limit of zero must still admit exactly one accelerator command; a design that took zero literally would starve the class. When both classes arrive with a single free slot, a design that ignored the pairing would overfill the queue or would reverse the order. Long random traffic with limit rewrites exposes lost or repeated commands, tag errors and a count that drifts.

// File: rtl/cmdq_share_pkg.sv
package cmdq_share_pkg;
  localparam int unsigned LIM_W = 8;
  localparam logic [LIM_W-1:0] LIM_RST = 8'd2;
  typedef enum logic {CLS_CPU = 1'b0, CLS_ACC = 1'b1} cls_e;
endpackage

// File: rtl/cmdq_lim_reg.sv
module cmdq_lim_reg
  import cmdq_share_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LIM_W-1:0] wdata,
  output logic [LIM_W-1:0] lim_q,
  output logic [LIM_W-1:0] lim_eff
);
  logic [LIM_W-1:0] lim_nxt;

  always_comb begin
    lim_nxt = lim_q;
    if (we) lim_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lim_q <= LIM_RST;
    else        lim_q <= lim_nxt;
  end

  // zero is illegal: fold it onto the smallest legal cap
  always_comb begin
    lim_eff = lim_q;
    if (lim_q == '0) lim_eff = LIM_W'(1);
  end

  a_r2_limit_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (lim_q == $past(wdata)));
  a_r2_limit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(lim_q));
endmodule

// File: rtl/cmdq_admit.sv
module cmdq_admit
  import cmdq_share_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             acc_valid,
  input  logic [LIM_W-1:0] lim_eff,
  input  logic             pop,
  input  logic             pop_tag,
  output logic             cpu_ready,
  output logic             acc_ready,
  output logic             cpu_push,
  output logic             acc_push,
  output logic             not_empty
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned CMP_W = (CNT_W > LIM_W) ? CNT_W : LIM_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] acc_q, acc_nxt;
  logic             has1, has2, acc_below, acc_pop;

  always_comb begin
    has1      = (cnt_q != DEPTH_C);
    has2      = (cnt_q < (DEPTH_C - CNT_W'(1)));
    acc_below = (CMP_W'(acc_q) < CMP_W'(lim_eff));
    cpu_ready = has1;
    cpu_push  = cpu_valid & has1;
    // processor command goes first; accelerator needs the following slot
    acc_ready = acc_below & (cpu_push ? has2 : has1);
    acc_push  = acc_valid & acc_ready;
    not_empty = (cnt_q != '0);
    acc_pop   = pop & pop_tag;
  end

  always_comb begin
    cnt_nxt = cnt_q + CNT_W'(cpu_push) + CNT_W'(acc_push) - CNT_W'(pop);
    acc_nxt = acc_q + CNT_W'(acc_push) - CNT_W'(acc_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      acc_q <= acc_nxt;
    end
  end

  a_r3_push_under_cap: assert property (@(posedge clk) disable iff (!rst_n)
    acc_push |-> (CMP_W'(acc_q) < CMP_W'(lim_eff)));
  a_r8_acc_within_total: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= cnt_q);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  a_r5_cpu_uncapped: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < DEPTH_C) |-> cpu_ready);
  a_r8_acc_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_push && !acc_pop) |=> (acc_q == $past(acc_q) + CNT_W'(1)));
endmodule

// File: rtl/cmdq_store.sv
module cmdq_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr0_en,
  input  logic              wr0_tag,
  input  logic [DATA_W-1:0] wr0_data,
  input  logic              wr1_en,
  input  logic              wr1_tag,
  input  logic [DATA_W-1:0] wr1_data,
  input  logic              rd_en,
  output logic              rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  // DEPTH must be a power of two so the pointers wrap naturally
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned ENT_W = DATA_W + 1;

  logic [PTR_W-1:0] wptr_q, wptr_nxt, wptr_p1;
  logic [PTR_W-1:0] rptr_q, rptr_nxt;
  logic [ENT_W-1:0] mem [DEPTH];

  always_comb begin
    wptr_p1  = wptr_q + PTR_W'(1);
    wptr_nxt = wptr_q + PTR_W'(wr0_en) + PTR_W'(wr1_en);
    rptr_nxt = rptr_q + PTR_W'(rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_nxt;
      rptr_q <= rptr_nxt;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic sel0, sel1;
    assign sel0 = wr0_en && (wptr_q == PTR_W'(i));
    assign sel1 = wr1_en && (wptr_p1 == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (sel0)      mem[i] <= {wr0_tag, wr0_data};
      else if (sel1) mem[i] <= {wr1_tag, wr1_data};
    end
  end

  always_comb begin
    {rd_tag, rd_data} = mem[rptr_q];
  end

  a_r6_pair_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> wr0_en);
endmodule

// File: rtl/cmdq_share_adm.sv
module cmdq_share_adm
  import cmdq_share_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lim_we,
  input  logic [7:0]        lim_wdata,
  output logic [7:0]        lim_q,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [DATA_W-1:0] acc_data,
  output logic              deq_valid,
  input  logic              deq_ready,
  output logic [DATA_W-1:0] deq_data,
  output logic              deq_is_acc
);
  logic [LIM_W-1:0]  lim_eff;
  logic              cpu_push, acc_push, pop, not_empty;
  logic              wr0_en, wr0_tag, wr1_en;
  logic [DATA_W-1:0] wr0_data;

  cmdq_lim_reg u_lim (
    .clk(clk), .rst_n(rst_n), .we(lim_we), .wdata(lim_wdata),
    .lim_q(lim_q), .lim_eff(lim_eff)
  );

  cmdq_admit #(.DEPTH(DEPTH)) u_adm (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .acc_valid(acc_valid),
    .lim_eff(lim_eff), .pop(pop), .pop_tag(deq_is_acc),
    .cpu_ready(cpu_ready), .acc_ready(acc_ready),
    .cpu_push(cpu_push), .acc_push(acc_push), .not_empty(not_empty)
  );

  always_comb begin
    deq_valid = not_empty;
    pop       = not_empty & deq_ready;
    wr0_en    = cpu_push | acc_push;
    wr0_tag   = cpu_push ? CLS_CPU : CLS_ACC;
    wr0_data  = cpu_push ? cpu_data : acc_data;
    wr1_en    = cpu_push & acc_push;
  end

  cmdq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_sto (
    .clk(clk), .rst_n(rst_n),
    .wr0_en(wr0_en), .wr0_tag(wr0_tag), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_tag(CLS_ACC), .wr1_data(acc_data),
    .rd_en(pop), .rd_tag(deq_is_acc), .rd_data(deq_data)
  );

  a_r9_full_blocks_both: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> !acc_ready);
  a_r4_zero_admits_one: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == 8'd0 && !deq_valid && !cpu_valid) |-> acc_ready);
endmodule

// File: tb/cmdq_share_adm_tb_top.sv
module cmdq_share_adm_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int DW    = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lim_we;
  logic [7:0]    lim_wdata, lim_q;
  logic          cpu_valid, cpu_ready, acc_valid, acc_ready;
  logic [DW-1:0] cpu_data, acc_data, deq_data;
  logic          deq_valid, deq_ready, deq_is_acc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [DW:0] mq[$];
  int m_acc = 0;
  int m_lim = 2;
  int seq   = 0;

  always #(CLK_P/2) clk = ~clk;

  cmdq_share_adm #(.DEPTH(DEPTH), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lim_we(lim_we), .lim_wdata(lim_wdata),
    .lim_q(lim_q), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_data(cpu_data), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_data(acc_data), .deq_valid(deq_valid), .deq_ready(deq_ready),
    .deq_data(deq_data), .deq_is_acc(deq_is_acc)
  );

  task automatic chk(string req, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic drive(bit cv, bit av, bit dr, bit we = 0, int wv = 0);
    cpu_valid = cv; acc_valid = av; deq_ready = dr;
    lim_we = we; lim_wdata = 8'(wv);
    cpu_data = DW'(seq); acc_data = DW'(seq + 1);
    seq += 2;
  endtask

  // compare against the model, then advance it; the caller drives at the negedge
  task automatic eval(string acc_tag);
    int free, lim_eff;
    bit e_cr, e_ar, ctake, atake, pop;
    #1;
    free    = DEPTH - mq.size();
    lim_eff = (m_lim == 0) ? 1 : m_lim;
    e_cr    = free >= 1;
    ctake   = cpu_valid && e_cr;
    e_ar    = (m_acc < lim_eff) && (ctake ? free >= 2 : free >= 1);
    atake   = acc_valid && e_ar;
    chk((free == 0) ? "R9" : "R5", "cpu_ready", int'(cpu_ready), int'(e_cr));
    chk((free == 0) ? "R9" : acc_tag, "acc_ready", int'(acc_ready), int'(e_ar));
    chk("R9", "deq_valid", int'(deq_valid), int'(mq.size() > 0));
    chk("R2", "lim_q", int'(lim_q), m_lim);
    if (mq.size() > 0) begin
      chk("R7", "deq_data", int'(deq_data), int'(mq[0][DW-1:0]));
      chk("R8", "deq_is_acc", int'(deq_is_acc), int'(mq[0][DW]));
    end
    pop = (mq.size() > 0) && deq_ready;
    if (pop) begin
      if (mq[0][DW]) m_acc--;
      void'(mq.pop_front());
    end
    if (ctake) mq.push_back({1'b0, cpu_data});
    if (atake) begin
      mq.push_back({1'b1, acc_data});
      m_acc++;
    end
    if (lim_we) m_lim = int'(lim_wdata);
    @(negedge clk);
  endtask

  task automatic drain();
    while (mq.size() > 0) begin
      drive(0, 0, 1);
      eval("R7");
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    #1;
    chk("R1", "deq_valid", int'(deq_valid), 0);
    chk("R1", "lim_q", int'(lim_q), 2);
    @(negedge clk);

    // R3: default cap of two, third accelerator command backed off
    for (int i = 0; i < 4; i++) begin drive(0, 1, 0); eval("R3"); end
    drive(0, 0, 1); eval("R3");
    for (int i = 0; i < 2; i++) begin drive(0, 1, 0); eval("R3"); end
    drain();

    // R4: limit zero behaves as one
    drive(0, 0, 0, 1, 0); eval("R2");
    for (int i = 0; i < 3; i++) begin drive(0, 1, 0); eval("R4"); end
    drive(0, 1, 1); eval("R4");
    drive(0, 1, 0); eval("R4");
    drain();

    // R5: processor fills the queue despite a tight cap
    drive(0, 0, 0, 1, 1); eval("R2");
    drive(0, 1, 0); eval("R3");
    for (int i = 0; i < DEPTH + 2; i++) begin drive(1, 1, 0); eval("R5"); end
    // R9: dequeue while full, readies stay low this cycle
    drive(1, 1, 1); eval("R9");
    drive(0, 0, 0, 1, 8); eval("R9");
    // R6: one free slot, both offered, processor only
    drive(1, 1, 0); eval("R6");
    drive(0, 0, 1); eval("R6");
    drive(0, 0, 1); eval("R6");
    drive(1, 1, 0); eval("R6");
    drain();

    // R8 / R7: random traffic with limit rewrites
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom_range(0, 40) == 0);
      drive(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 2) != 0),
            bit'($urandom_range(0, 3) != 0), we, $urandom_range(0, 12));
      eval("R8");
    end
    drain();
    drive(0, 0, 0); eval("R7");

    done = 1;
    summary();
    $finish;
  end
endmodule